// File: doc/BRIEF.md
# Weighted Incremental Countdown Timer

This block is a real-time timing engine. Software loads a starting count and four signed 24-bit weights, then issues an enter command. From then on, every word-time tick either applies a fixed bias or samples one of three incremental inputs. Each input carries 0, +1 or -1. A sampled input adds its value times its own weight to a 24-bit two's-complement count register.

Input 1 has the faster sampling rate, once every two word times. Inputs 2 and 3 are each sampled once every four word times. The sampling order is fixed by a four-slot rotation that starts after one settling word time. The count register is tested at every running tick. Once its sign bit is seen set, a sticky discrete output is raised and stays up until a clear command removes it. This lets a program pad a routine to a fixed length: it loads the count, enters the mode, and waits for the discrete.

Top module: `fine_countdown`

## Requirements
- R1: After reset the count is 0, the discrete output is low, the engine is stopped and all four weights are 0.
- R2: `enter_cmd` starts the engine and `halt_cmd` stops it. If both are high in the same cycle, halt wins. A tick in a cycle where the engine is stopped, or where enter or halt is high, leaves the count unchanged.
- R3: The first accepted tick after entry is a settling word time. It subtracts weight 0 from the count and samples no input.
- R4: After the settling tick, accepted ticks walk a four-slot rotation starting at slot 0. Slot 0 samples input 1 with weight 1. Slot 1 samples input 2 with weight 2. Slot 2 samples input 1 with weight 1. Slot 3 samples input 3 with weight 3. The rotation then repeats.
- R5: Input codes are 2'b01 for +1, 2'b11 for -1, and 2'b00 or 2'b10 for 0. A sampled input adds its value times its weight to the count, in 24-bit two's-complement arithmetic that wraps on overflow.
- R6: On an accepted tick where the count's sign bit (bit 23) is already 1, the discrete output is set. It stays high until `det_clear`, which clears it and wins over a set in the same cycle.
- R7: With every weight equal to 1 and all inputs at -1, a starting count Ku ≥ 0 raises the discrete output on the (Ku+2)-th accepted tick after entry, and not before.
- R8: A weight may be rewritten while the engine runs. The next tick that uses that weight applies the new value.
- R9: `count_load` writes `load_data` into the count in the next cycle, overriding any update from a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Word-time strobe, one cycle wide |
| enter_cmd | input | 1 | Start the countdown mode |
| halt_cmd | input | 1 | Stop the countdown mode |
| det_clear | input | 1 | Clear the detector and discrete output |
| count_load | input | 1 | Write load_data into the count |
| weight_load | input | 1 | Write load_data into the weight chosen by weight_sel |
| weight_sel | input | 2 | Weight index 0..3 |
| load_data | input | 24 | Shared load value |
| inc1 | input | 2 | Incremental input 1 code |
| inc2 | input | 2 | Incremental input 2 code |
| inc3 | input | 2 | Incremental input 3 code |
| disc_out | output | 1 | Sticky discrete output |
| count_out | output | 24 | Current count |

## Verification
The table-driven part mixes input patterns and compares the result with a bench model that restates the slot rotation:
- all inputs at +1 exposes a missing or extra sampling slot;
- mixed signs with distinct weights (2, 3, 5, 7) tell the slots apart and show whether a wrong weight pairs with an input;
- the 2'b10 and 2'b00 codes are checked for having no effect;
- a count at the positive limit checks the wrap into the sign bit;
- a negative weight checks the sign handling.

Directed runs then check the Ku+2 firing edge one tick early and on time, then ticks ignored while halted, then the weight rewrite, load priority and clear priority.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Incremental input codes
  typedef enum logic [1:0] {
    INC_ZERO = 2'b00,
    INC_UP   = 2'b01,
    INC_ALT0 = 2'b10,
    INC_DOWN = 2'b11
  } inc_code_e;

  // Rotation slots after the settling word time
  typedef enum logic [1:0] {
    SLOT_IN1_A = 2'd0,
    SLOT_IN2   = 2'd1,
    SLOT_IN1_B = 2'd2,
    SLOT_IN3   = 2'd3
  } slot_e;

  localparam int N_WEIGHTS = 4;
  localparam int N_INPUTS  = 3;

endpackage

// File: rtl/fcd_weights.sv
module fcd_weights
  import fcd_pkg::*;
#(
  parameter int DW = 24,
  parameter int NW = N_WEIGHTS,
  localparam int SEL_W = $clog2(NW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [DW-1:0]        wdata,
  output logic [NW-1:0][DW-1:0] weights
);

  logic [DW-1:0] bank [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) bank[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NW; i++) begin
        if (sel == SEL_W'(i)) bank[i] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_out
    assign weights[g] = bank[g];
  end

endmodule

// File: rtl/fcd_sched.sv
module fcd_sched
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enter_cmd,
  input  logic       halt_cmd,
  output logic       run_q,
  output logic       settle_q,
  output logic [1:0] phase_q,
  output logic       step
);

  // A tick counts only while running and with no command in the same cycle
  assign step = tick && run_q && !enter_cmd && !halt_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      settle_q <= 1'b0;
      phase_q  <= 2'd0;
    end else if (halt_cmd) begin
      run_q <= 1'b0;
    end else if (enter_cmd) begin
      run_q    <= 1'b1;
      settle_q <= 1'b1;
      phase_q  <= 2'd0;
    end else if (step) begin
      if (settle_q) settle_q <= 1'b0;
      else          phase_q  <= phase_q + 2'd1;
    end
  end

endmodule

// File: rtl/fcd_accum.sv
module fcd_accum
  import fcd_pkg::*;
#(
  parameter int DW = 24,
  parameter int NW = N_WEIGHTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  settle,
  input  logic [1:0]            phase,
  input  logic [1:0]            inc1,
  input  logic [1:0]            inc2,
  input  logic [1:0]            inc3,
  input  logic [NW-1:0][DW-1:0] weights,
  input  logic                  load_en,
  input  logic [DW-1:0]         load_data,
  input  logic                  clr_det,
  output logic [DW-1:0]         count,
  output logic                  det,
  output logic [DW-1:0]         delta,
  output logic                  fire
);

  // value (0, +1, -1) times weight
  function automatic logic [DW-1:0] weighted(input logic [1:0] code,
                                             input logic [DW-1:0] k);
    case (inc_code_e'(code))
      INC_UP:   return k;
      INC_DOWN: return '0 - k;
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    if (settle) begin
      delta = '0 - weights[0];
    end else begin
      case (slot_e'(phase))
        SLOT_IN1_A, SLOT_IN1_B: delta = weighted(inc1, weights[1]);
        SLOT_IN2:               delta = weighted(inc2, weights[2]);
        default:                delta = weighted(inc3, weights[3]);
      endcase
    end
  end

  assign fire = step && count[DW-1] && !det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_data;
    else if (step)    count <= count + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      det <= 1'b0;
    else if (clr_det)                det <= 1'b0;
    else if (step && count[DW-1])    det <= 1'b1;
  end

endmodule

// File: rtl/fine_countdown.sv
module fine_countdown
  import fcd_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int SEL_W = $clog2(N_WEIGHTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enter_cmd,
  input  logic              halt_cmd,
  input  logic              det_clear,
  input  logic              count_load,
  input  logic              weight_load,
  input  logic [SEL_W-1:0]  weight_sel,
  input  logic [DATA_W-1:0] load_data,
  input  logic [1:0]        inc1,
  input  logic [1:0]        inc2,
  input  logic [1:0]        inc3,
  output logic              disc_out,
  output logic [DATA_W-1:0] count_out
);

  logic                         run_q;
  logic                         settle_q;
  logic [1:0]                   phase_q;
  logic                         step_w;
  logic                         fire_w;
  logic [DATA_W-1:0]            delta_w;
  logic [N_WEIGHTS-1:0][DATA_W-1:0] weights_w;

  fcd_weights #(.DW(DATA_W), .NW(N_WEIGHTS)) u_weights (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (weight_load),
    .sel     (weight_sel),
    .wdata   (load_data),
    .weights (weights_w)
  );

  fcd_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enter_cmd (enter_cmd),
    .halt_cmd  (halt_cmd),
    .run_q     (run_q),
    .settle_q  (settle_q),
    .phase_q   (phase_q),
    .step      (step_w)
  );

  fcd_accum #(.DW(DATA_W), .NW(N_WEIGHTS)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step_w),
    .settle    (settle_q),
    .phase     (phase_q),
    .inc1      (inc1),
    .inc2      (inc2),
    .inc3      (inc3),
    .weights   (weights_w),
    .load_en   (count_load),
    .load_data (load_data),
    .clr_det   (det_clear),
    .count     (count_out),
    .det       (disc_out),
    .delta     (delta_w),
    .fire      (fire_w)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt_cmd,
  input logic          det_clear,
  input logic          count_load,
  input logic [DW-1:0] load_data,
  input logic          run_q,
  input logic          settle_q,
  input logic [1:0]    phase_q,
  input logic          step_w,
  input logic          fire_w,
  input logic          disc_out,
  input logic [DW-1:0] count_out
);

  a_r2_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !run_q);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_w && !count_load) |=> $stable(count_out));

  a_r3_settle_once: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && settle_q) |=> !settle_q);

  a_r4_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !settle_q) |=> phase_q == $past(phase_q) + 2'd1);

  a_r6_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !det_clear) |=> disc_out);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_out && !det_clear) |=> disc_out);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    det_clear |=> !disc_out);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    count_load |=> count_out == $past(load_data));

endmodule

bind fine_countdown fcd_checker #(.DW(DATA_W)) u_fcd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_cmd   (halt_cmd),
  .det_clear  (det_clear),
  .count_load (count_load),
  .load_data  (load_data),
  .run_q      (run_q),
  .settle_q   (settle_q),
  .phase_q    (phase_q),
  .step_w     (step_w),
  .fire_w     (fire_w),
  .disc_out   (disc_out),
  .count_out  (count_out)
);

// File: tb/fine_countdown_bench.sv
module fine_countdown_bench;

  localparam logic [1:0] UP = 2'b01, DN = 2'b11, ZR = 2'b00, AZ = 2'b10;

  typedef struct packed {
    logic [23:0] ku, k0, k1, k2, k3;
    logic [1:0]  c1, c2, c3;
    logic [7:0]  n;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{ku:24'd100,     k0:24'd0, k1:24'd1, k2:24'd1, k3:24'd1, c1:UP, c2:UP, c3:UP, n:8'd9},
    '{ku:24'd100,     k0:24'd2, k1:24'd3, k2:24'd5, k3:24'd7, c1:DN, c2:UP, c3:DN, n:8'd10},
    '{ku:24'd50,      k0:24'd1, k1:24'd1, k2:24'd1, k3:24'd1, c1:ZR, c2:AZ, c3:UP, n:8'd7},
    '{ku:24'h7FFFFF,  k0:24'd0, k1:24'd1, k2:24'd0, k3:24'd0, c1:UP, c2:ZR, c3:ZR, n:8'd3},
    '{ku:24'd1000,    k0:24'd0, k1:24'hFFFFFF, k2:24'd2, k3:24'd3, c1:UP, c2:DN, c3:DN, n:8'd8}
  };

  logic clk = 0, rst_n = 0;
  logic tick = 0, enter_cmd = 0, halt_cmd = 0, det_clear = 0;
  logic count_load = 0, weight_load = 0;
  logic [1:0] weight_sel = 0;
  logic [23:0] load_data = 0;
  logic [1:0] inc1 = 0, inc2 = 0, inc3 = 0;
  logic disc_out;
  logic [23:0] count_out;
  int errors = 0, checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  fine_countdown u_fine_countdown (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enter_cmd(enter_cmd),
    .halt_cmd(halt_cmd), .det_clear(det_clear), .count_load(count_load),
    .weight_load(weight_load), .weight_sel(weight_sel), .load_data(load_data),
    .inc1(inc1), .inc2(inc2), .inc3(inc3), .disc_out(disc_out),
    .count_out(count_out)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench restatement of a weighted increment
  function automatic logic [23:0] term(logic [1:0] c, logic [23:0] k);
    if (c == UP) return k;
    if (c == DN) return 24'd0 - k;
    return 24'd0;
  endfunction

  function automatic logic [24:0] model(vec_t v);
    logic [23:0] c = v.ku;
    logic d = 1'b0;
    for (int k = 1; k <= int'(v.n); k++) begin
      if (c[23]) d = 1'b1;
      if (k == 1) c = c - v.k0;
      else begin
        int s = (k - 2) % 4;
        if (s == 0 || s == 2) c = c + term(v.c1, v.k1);
        else if (s == 1)      c = c + term(v.c2, v.k2);
        else                  c = c + term(v.c3, v.k3);
      end
    end
    return {d, c};
  endfunction

  task automatic pulse_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask
  task automatic pulse_enter();
    @(negedge clk) enter_cmd = 1;
    @(negedge clk) enter_cmd = 0;
  endtask
  task automatic pulse_halt();
    @(negedge clk) halt_cmd = 1;
    @(negedge clk) halt_cmd = 0;
  endtask
  task automatic pulse_clear();
    @(negedge clk) det_clear = 1;
    @(negedge clk) det_clear = 0;
  endtask
  task automatic load_count(logic [23:0] v);
    @(negedge clk) begin count_load = 1; load_data = v; end
    @(negedge clk) count_load = 0;
  endtask
  task automatic load_weight(logic [1:0] s, logic [23:0] v);
    @(negedge clk) begin weight_load = 1; weight_sel = s; load_data = v; end
    @(negedge clk) weight_load = 0;
  endtask
  task automatic setup(vec_t v);
    pulse_halt();
    pulse_clear();
    load_weight(2'd0, v.k0);
    load_weight(2'd1, v.k1);
    load_weight(2'd2, v.k2);
    load_weight(2'd3, v.k3);
    load_count(v.ku);
    inc1 = v.c1; inc2 = v.c2; inc3 = v.c3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count_out), 32'd0);
    check("R1 disc", 32'(disc_out), 32'd0);
    rst_n = 1;
    // R1: weights zero -> settling subtracts 0, slot0 with +1 adds 0
    load_count(24'd40);
    inc1 = UP; inc2 = UP; inc3 = UP;
    pulse_enter();
    pulse_tick(); pulse_tick();
    check("R1 zero weights", 32'(count_out), 32'd40);
    pulse_halt();

    // Table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [24:0] exp;
      exp = model(VECS[i]);
      setup(VECS[i]);
      pulse_enter();
      for (int t = 0; t < int'(VECS[i].n); t++) pulse_tick();
      check($sformatf("R4/R5 vec%0d count", i), 32'(count_out), 32'(exp[23:0]));
      check($sformatf("R6 vec%0d disc", i), 32'(disc_out), 32'(exp[24]));
    end

    // R7: Ku+2 firing with unit weights and -1 inputs
    setup('{ku:24'd6, k0:24'd1, k1:24'd1, k2:24'd1, k3:24'd1, c1:DN, c2:DN, c3:DN, n:8'd0});
    pulse_enter();
    repeat (7) pulse_tick();
    check("R7 not before Ku+2", 32'(disc_out), 32'd0);
    pulse_tick();
    check("R7 fires at Ku+2", 32'(disc_out), 32'd1);
    pulse_tick();
    check("R6 sticky", 32'(disc_out), 32'd1);
    // R6 clear wins over a set on the same cycle
    @(negedge clk) begin tick = 1; det_clear = 1; end
    @(negedge clk) begin tick = 0; det_clear = 0; end
    check("R6 clear priority", 32'(disc_out), 32'd0);

    // R2 halted ticks ignored
    pulse_halt();
    load_count(24'd77);
    repeat (3) pulse_tick();
    check("R2 halted ticks", 32'(count_out), 32'd77);
    // R2 enter+halt together: halt wins
    @(negedge clk) begin enter_cmd = 1; halt_cmd = 1; end
    @(negedge clk) begin enter_cmd = 0; halt_cmd = 0; end
    repeat (2) pulse_tick();
    check("R2 halt wins", 32'(count_out), 32'd77);

    // R8 weight rewrite while running
    setup('{ku:24'd100, k0:24'd0, k1:24'd1, k2:24'd1, k3:24'd1, c1:UP, c2:UP, c3:UP, n:8'd0});
    pulse_enter();
    pulse_tick(); pulse_tick();
    check("R8 before rewrite", 32'(count_out), 32'd101);
    load_weight(2'd2, 24'd10);
    pulse_tick();
    check("R8 new weight used", 32'(count_out), 32'd111);

    // R9 load wins over a tick in the same cycle
    @(negedge clk) begin tick = 1; count_load = 1; load_data = 24'd500; end
    @(negedge clk) begin tick = 0; count_load = 0; end
    check("R9 load priority", 32'(count_out), 32'd500);
    pulse_tick();  // slot 3: +1
    check("R9 continues after load", 32'(count_out), 32'd501);

    finish_run();
  end

endmodule